// File: doc/BRIEF.md
# SPI Status Register Write Controller

This block is the command front end of a serial flash device that handles two SPI commands: the one that arms writing and the one that writes the protection settings. It receives chip enable, serial clock, serial data and the write-protect pin. It keeps an 8-bit status word with a busy flag, a write-enable latch, three block-protect bits, a top/bottom select bit and a protect-lock bit. Serial data out is never driven by these commands, so the output-enable for that pin stays low.

All four serial inputs are sampled by a fast internal clock and synchronised. Every bit is shifted in MSB first on a rising serial clock edge, so SPI mode 0 and mode 3 both work. The decision on a command is taken only when chip enable returns high. A status write is then accepted or refused from the enable latch, the lock bit and the level of the write-protect pin at that moment.

Top module: `spi_sr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `status` becomes 0x1C (block-protect bits set; busy, latch, top/bottom, reserved and lock bits clear). `so_en` is 0.
- R2: A frame of exactly 8 bits with the value 0x06 sets the write-enable latch (status bit 1). The status output changes on the third rising `clk` edge after `ce_n` goes high.
- R3: A write-status frame (16 bits, first byte 0x01) that arrives while the latch is clear leaves the status word unchanged.
- R4: An accepted write-status frame copies data bit 7 to the lock bit, bit 5 to top/bottom and bits 4..2 to the protect bits. Bits 0, 1 and 6 of the status word then read 0. Every write-status frame, accepted or refused, clears the latch.
- R5: If `wp_n` is high when the frame ends, the write is accepted even with the lock bit set, and it may clear the lock bit.
- R6: If `wp_n` is low and the lock bit is 1, the write-status frame changes no bit other than clearing the latch.
- R7: With `wp_n` low and the lock bit 0, one frame may set the lock bit and change top/bottom and the protect bits at the same time.
- R8: A frame whose bit count is not 8 or 16, or whose opcode does not match its length, changes nothing, and the latch keeps its value.
- R9: `so_en` is 0 at all times.
- R10: Frames sent in mode 0 (`sck` idle low) and in mode 3 (`sck` idle high) give the same result.
- R11: Only the level of `wp_n` at the rising edge of `ce_n` counts. Its level while the bits are shifted has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, at least 4x the `sck` rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, frames a command |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Current status word |
| so_en | output | 1 | Output enable for serial data out |

## Verification
A wrong bit count or a wrong shift register shows up as a command that is taken or dropped in error. The status word then differs three clocks after `ce_n` rises, and the reference model flags it on that clock. A wrong latch or lock state may stay hidden until the next write-status frame, so each scenario writes after it arms or locks. The write-protect pin is also moved between the shift phase and the end of the frame, so that a sample taken at the wrong moment changes the result.

// File: rtl/spi_sr_pkg.sv
// Shared constants and the status word layout for the status write controller.
package spi_sr_pkg;

    localparam int STAT_W     = 8;
    localparam int OP_W       = 8;
    localparam int ARM_BITS   = OP_W;
    localparam int WRITE_BITS = 2 * OP_W;

    localparam logic [OP_W-1:0] OP_ARM   = 8'h06;
    localparam logic [OP_W-1:0] OP_WRITE = 8'h01;

    // Bits of the status word that a status write may change.
    localparam logic [STAT_W-1:0] WR_MASK = 8'b1011_1100;
    localparam logic [STAT_W-1:0] RESET_STATUS = 8'h1C;

    typedef struct packed {
        logic       lock;
        logic       rsv;
        logic       tb;
        logic [2:0] bp;
        logic       wel;
        logic       busy;
    } status_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ARM   = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/spi_sr_sync.sv
// Synchroniser chain for a vector of slow asynchronous inputs.
// Assumes each input level stays for at least two clk periods.
module spi_sr_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Move each input one stage further along the chain.
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_sr_edge.sv
// Rising-edge detector for synchronised single-bit signals.
// Assumes the input is already in the clk domain.
module spi_sr_edge #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev;

    // Keep the previous level so a low-to-high change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/spi_sr_shift.sv
// Serial input shifter and saturating bit counter for one frame.
// Assumes that sck_rise is a single-cycle pulse and that a deasserted
// chip enable ends the frame.
module spi_sr_shift #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               sck_rise,
    input  logic               si,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   count
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    // Shift data in MSB first, and clear the frame while not selected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            frame <= '0;
        end else if (sck_rise) begin
            frame <= {frame[FRAME_W-2:0], si};
        end
    end

    // Count received bits. The count stops at FRAME_W+1, which marks an overlong frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            count <= '0;
        end else if (sck_rise && count != CNT_SAT) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/spi_sr_decode.sv
// Classifies a finished frame by its exact length and its opcode byte.
// Purely combinational. The result is used only on the clock where the
// frame ends.
module spi_sr_decode
    import spi_sr_pkg::*;
#(
    parameter int FRAME_W = WRITE_BITS,
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   count,
    output cmd_e               cmd,
    output logic [OP_W-1:0]    data
);

    localparam logic [CNT_W-1:0] N_ARM   = CNT_W'(ARM_BITS);
    localparam logic [CNT_W-1:0] N_WRITE = CNT_W'(WRITE_BITS);

    // Match the length together with the opcode. Anything else is dropped.
    always_comb begin
        cmd = CMD_NONE;
        if (count == N_ARM && frame[OP_W-1:0] == OP_ARM) begin
            cmd = CMD_ARM;
        end else if (count == N_WRITE && frame[FRAME_W-1:OP_W] == OP_WRITE) begin
            cmd = CMD_WRITE;
        end
    end

    assign data = frame[OP_W-1:0];

endmodule

// File: rtl/spi_sr_status.sv
// Holds the status word and applies a command when chip enable rises.
// Assumes commit is a single-cycle pulse and wp_ok is the synchronised pin.
module spi_sr_status
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cmd_e              cmd,
    input  logic [OP_W-1:0]   data,
    input  logic              wp_ok,
    output logic [STAT_W-1:0] status
);

    status_t cur;
    status_t nxt;
    logic    allow;

    // A write needs the latch, and either the pin high or the lock bit clear.
    assign allow = cur.wel && (wp_ok || !cur.lock);

    // Work out the next status word from the command that just ended.
    always_comb begin
        nxt = cur;
        if (commit) begin
            unique case (cmd)
                CMD_ARM: begin
                    nxt.wel = 1'b1;
                end
                CMD_WRITE: begin
                    if (allow) begin
                        nxt = status_t'((data & WR_MASK) | (cur & ~WR_MASK));
                    end
                    nxt.wel = 1'b0;
                end
                default: begin
                    nxt = cur;
                end
            endcase
        end
        nxt.busy = 1'b0;
        nxt.rsv  = 1'b0;
    end

    // Store the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= status_t'(RESET_STATUS);
        else        cur <= nxt;
    end

    assign status = cur;

endmodule

// File: rtl/spi_sr_ctrl.sv
// Top level: samples the SPI pins, assembles frames and updates the status word.
// Assumes clk runs at least four times faster than sck, and that every pin
// level stays for at least two clk periods.
module spi_sr_ctrl
    import spi_sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_W     = WRITE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              sck,
    input  logic              si,
    input  logic              wp_n,
    output logic [STAT_W-1:0] status,
    output logic              so_en
);

    localparam int CNT_W = $clog2(FRAME_W + 2);

    logic [3:0]         pins_s;
    logic               ce_n_s;
    logic               sck_s;
    logic               si_s;
    logic               wp_s;
    logic [1:0]         rises;
    logic               ce_rise;
    logic               sck_rise;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   count;
    cmd_e               cmd;
    logic [OP_W-1:0]    data;
    logic               cmd_arm;
    logic               cmd_write;

    spi_sr_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({wp_n, si, sck, ce_n}),
        .q    (pins_s)
    );

    assign ce_n_s = pins_s[0];
    assign sck_s  = pins_s[1];
    assign si_s   = pins_s[2];
    assign wp_s   = pins_s[3];

    spi_sr_edge #(
        .WIDTH  (2),
        .RST_VAL(2'b01)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({sck_s, ce_n_s}),
        .rise (rises)
    );

    assign ce_rise  = rises[0];
    assign sck_rise = rises[1];

    spi_sr_shift #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (!ce_n_s),
        .sck_rise(sck_rise),
        .si      (si_s),
        .frame   (frame),
        .count   (count)
    );

    spi_sr_decode #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .frame(frame),
        .count(count),
        .cmd  (cmd),
        .data (data)
    );

    assign cmd_arm   = (cmd == CMD_ARM);
    assign cmd_write = (cmd == CMD_WRITE);

    spi_sr_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(ce_rise),
        .cmd   (cmd),
        .data  (data),
        .wp_ok (wp_s),
        .status(status)
    );

    // Neither command drives serial data out.
    assign so_en = 1'b0;

endmodule

// File: rtl/spi_sr_ctrl_chk.sv
// Assertion checker for spi_sr_ctrl, attached with bind.
module spi_sr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       ce_rise,
    input logic       wp_ok,
    input logic       is_arm,
    input logic       is_write
);

    // R1: reset loads the defined status value
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> status == 8'h1C);

    // R2: an accepted arm frame sets the latch
    a_r2_arm_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise && is_arm) |=> status[1]);

    // R3: a write while unarmed keeps the status word
    a_r3_unarmed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise && is_write && !status[1]) |=> $stable(status));

    // R4: every write frame clears the latch
    a_r4_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise && is_write) |=> !status[1]);

    // R6: a locked word with the pin low is not written
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise && !wp_ok && status[7]) |=> $stable(status[7:2]));

    // R8: the status word only moves at the end of a frame
    a_r8_no_change_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_rise |=> $stable(status));

endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .ce_rise (ce_rise),
    .wp_ok   (wp_s),
    .is_arm  (cmd_arm),
    .is_write(cmd_write)
);

// File: tb/spi_sr_ctrl_tb.sv
// Bench for spi_sr_ctrl: a behavioural model predicts the status word,
// and the output is compared with it on every clock.
module spi_sr_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic [7:0] status;
    logic       so_en;

    int    total = 0;
    int    bad = 0;
    logic  [7:0] expv = 8'h1C;
    logic  cmp_on = 1'b0;
    string tag = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    spi_sr_ctrl u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .sck   (sck),
        .si    (si),
        .wp_n  (wp_n),
        .status(status),
        .so_en (so_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp_v, $time);
        end
    endtask

    // Model of the requirements: the next status word after a frame.
    function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [23:0] v,
                                              input int n, input logic wp);
        logic [7:0] nx = cur;
        if (n == 8 && v[7:0] == 8'h06) begin
            nx[1] = 1'b1;
        end else if (n == 16 && v[15:8] == 8'h01) begin
            if (cur[1] && (wp || !cur[7])) begin
                nx[7]   = v[7];
                nx[5]   = v[5];
                nx[4:2] = v[4:2];
            end
            nx[1] = 1'b0;
        end
        return nx;
    endfunction

    // Send one frame of n bits. wp_s is held during the shift, wp_e at the end.
    task automatic frame_tx(input logic [23:0] v, input int n, input bit mode3,
                            input logic wp_s, input logic wp_e);
        logic [7:0] nx;
        @(negedge clk);
        sck  = mode3;
        wp_n = wp_s;
        repeat (4) @(negedge clk);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            si = v[i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            if (!mode3) sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        wp_n = wp_e;
        repeat (4) @(negedge clk);
        nx = model_next(expv, v, n, wp_e);
        ce_n = 1'b1;
        repeat (3) @(posedge clk);
        expv = nx;
        repeat (6) @(negedge clk);
    endtask

    // Compare the status word and the output enable on every clock.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (cmp_on && !done) begin
                chk(tag, status, expv);
                chk("R9", {7'd0, so_en}, 8'd0);
            end
        end
    end

    // End a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", status, 8'h1C);
        chk("R1", {7'd0, so_en}, 8'd0);
        cmp_on = 1'b1;

        tag = "R3";
        frame_tx(24'h0180, 16, 1'b0, 1'b1, 1'b1);
        chk("R3", status, 8'h1C);

        tag = "R2";
        frame_tx(24'h06, 8, 1'b0, 1'b1, 1'b1);
        chk("R2", status, 8'h1E);

        tag = "R8";
        frame_tx(24'h0180, 15, 1'b0, 1'b1, 1'b1);
        chk("R8", status, 8'h1E);
        frame_tx(24'h0280, 16, 1'b0, 1'b1, 1'b1);
        chk("R8", status, 8'h1E);
        frame_tx(24'h0601, 16, 1'b1, 1'b1, 1'b1);
        chk("R8", status, 8'h1E);

        tag = "R7";
        frame_tx(24'h01A4, 16, 1'b0, 1'b0, 1'b0);
        chk("R7", status, 8'hA4);

        tag = "R10";
        frame_tx(24'h06, 8, 1'b1, 1'b0, 1'b0);
        chk("R10", status, 8'hA6);

        tag = "R6";
        frame_tx(24'h0100, 16, 1'b1, 1'b0, 1'b0);
        chk("R6", status, 8'hA4);

        tag = "R5";
        frame_tx(24'h06, 8, 1'b1, 1'b1, 1'b1);
        frame_tx(24'h015B, 16, 1'b1, 1'b1, 1'b1);
        chk("R5", status, 8'h18);

        tag = "R4";
        frame_tx(24'h06, 8, 1'b0, 1'b0, 1'b0);
        frame_tx(24'h01E3, 16, 1'b0, 1'b0, 1'b0);
        chk("R4", status, 8'hA0);

        tag = "R11";
        frame_tx(24'h06, 8, 1'b0, 1'b1, 1'b1);
        frame_tx(24'h0100, 16, 1'b0, 1'b1, 1'b0);
        chk("R11", status, 8'hA0);
        frame_tx(24'h06, 8, 1'b1, 1'b0, 1'b0);
        frame_tx(24'h0114, 16, 1'b1, 1'b0, 1'b1);
        chk("R11", status, 8'h14);

        tag = "R8";
        frame_tx(24'h0C, 7, 1'b0, 1'b1, 1'b1);
        chk("R8", status, 8'h14);
        frame_tx(24'h00C, 9, 1'b0, 1'b1, 1'b1);
        chk("R8", status, 8'h14);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule